// File: doc/BRIEF.md
# SMBus Block-Read Slave with Packet Error Code

This block is the slave side of an SMBus block read. It watches the clock and data lines through synchronized inputs, drives the data line only through an active-high pull-down enable, and recognises one fixed 7-bit address and one command code. After the master has written the address (write direction) and the command, it expects a repeated START and the same address in the read direction. It then returns a byte count, a run of data bytes fetched from a parallel register source, and a closing CRC-8 packet error code.

The parallel side presents a byte index, takes the data byte for that index in the same clock cycle, and gets a one-cycle strobe each time a byte is consumed. A busy flag from the parallel side makes the slave refuse the command byte. Clock stretching, timeouts and all other SMBus protocols are left to neighbouring logic.

Top module: `smbr_blkread_slave`

## Requirements
- R1: After reset, sda_oe is deasserted and rd_strb is low.
- R2: The first byte after a START is acknowledged only when its bits 7:1 equal SLV_ADDR and bit 0 is 0 (write). Any other first byte is not acknowledged, and sda_oe stays deasserted until the next START or STOP.
- R3: The command byte is acknowledged only when it equals BLK_CMD and busy_i is low; otherwise it is not acknowledged.
- R4: After the command ACK, a repeated START followed by SLV_ADDR with bit 0 = 1 (read) is acknowledged, and the first returned byte is the byte count, equal to DATA_LEN (16 by default).
- R5: The count is followed by the data bytes for indices 0 to DATA_LEN-1 in ascending order, each being rd_data while rd_idx shows that index, sent MSB first; rd_strb pulses once for each byte taken.
- R6: After the last data byte the slave sends a PEC byte: CRC-8, polynomial x^8+x^2+x+1 (0x07), initial value 0, bits fed MSB first, over every byte from the first address byte through the last data byte, both address bytes and the count included.
- R7: After the PEC byte the slave releases SDA whatever the master answers, and a following transaction is served from its beginning.
- R8: A master NACK on the count or on a data byte ends the transfer: the slave releases SDA and drives nothing more until the next START.
- R9: A START at any point other than the expected repeated START aborts the transaction; the slave returns to address matching and the PEC restarts from 0.
- R10: A STOP at any point returns the slave to idle, so a read-direction address that directly follows a new START is not acknowledged.
- R11: sda_oe changes only while SCL is low, and is asserted only to place a 0 on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_i | input | 1 | Parallel side busy; command byte is refused while high |
| rd_idx | output | IDX_W (4) | Index of the next data byte to fetch |
| rd_data | input | 8 | Data byte for rd_idx, valid in the same cycle |
| rd_strb | output | 1 | One-cycle pulse when the byte at rd_idx is taken |

## Verification
The situations hardest to reach from the pins are a START that lands inside a partly received command byte and a master that refuses a data byte mid-stream, since a well-behaved master never does either. The bench's master tasks drive the bus bit by bit, so a test can stop after any number of bits and raise a START, or answer a chosen byte with a NACK and then keep clocking to show that the slave stays silent. The aborted case is followed by a full block read whose PEC must match a CRC started afresh at the new address byte.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

   // protocol engine states
   typedef enum logic [2:0] {
      S_IDLE,    // waiting for START
      S_RX,      // shifting in a byte from the master
      S_RXACK,   // driving ACK for a received byte
      S_WAITRS,  // command accepted, waiting for repeated START
      S_TX,      // shifting out a byte to the master
      S_TXACK,   // sampling the master's ACK/NACK
      S_HOLD     // silent until START or STOP
   } smbr_state_t;

   // which byte is being received
   typedef enum logic [1:0] {
      P_ADDR_WR,
      P_CMD,
      P_ADDR_RD
   } smbr_rxph_t;

   // which byte is being transmitted
   typedef enum logic [1:0] {
      T_COUNT,
      T_DATA,
      T_PEC
   } smbr_txph_t;

   localparam logic [7:0] SMBR_PEC_POLY = 8'h07;

endpackage

// File: rtl/smbr_bus_sense.sv
// Synchronizes SCL/SDA and derives edge and START/STOP events.
module smbr_bus_sense #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 1) begin : g_bad_stages
      $error("smbr_bus_sense: STAGES must be at least 1");
   end

   logic [STAGES-1:0] scl_q;
   logic [STAGES-1:0] sda_q;
   logic              scl_p;
   logic              sda_p;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
         end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
         end
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
         end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_q[STAGES-1];
         sda_p <= sda_q[STAGES-1];
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign scl_rise  =  scl_s & ~scl_p;
   assign scl_fall  = ~scl_s &  scl_p;
   assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
   assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/smbr_crc8.sv
// One-byte step of an MSB-first CRC-8.
module smbr_crc8 #(
   parameter logic [7:0] POLY = 8'h07
) (
   input  logic [7:0] crc_i,
   input  logic [7:0] byte_i,
   output logic [7:0] crc_o
);

   always_comb begin
      logic [7:0] acc;
      acc = crc_i;
      for (int k = 0; k < 8; k++) begin
         if (acc[7] ^ byte_i[7-k]) acc = {acc[6:0], 1'b0} ^ POLY;
         else                      acc = {acc[6:0], 1'b0};
      end
      crc_o = acc;
   end

endmodule

// File: rtl/smbr_bytereg.sv
// Shared shift register for received and transmitted bytes.
module smbr_bytereg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       load,
   input  logic [7:0] load_val,
   input  logic       sample,
   input  logic       sample_bit,
   input  logic       adv,
   output logic [7:0] q,
   output logic [3:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= 8'h00;
         cnt <= 4'd0;
      end else if (clr) begin
         cnt <= 4'd0;
      end else if (load) begin
         q   <= load_val;
         cnt <= 4'd0;
      end else if (sample) begin
         q   <= {q[6:0], sample_bit};
         cnt <= cnt + 4'd1;
      end else if (adv) begin
         q   <= {q[6:0], 1'b1};
         cnt <= cnt + 4'd1;
      end
   end

endmodule

// File: rtl/smbr_blkread_slave.sv
module smbr_blkread_slave
   import smbr_pkg::*;
#(
   parameter logic [6:0] SLV_ADDR    = 7'h2A,
   parameter logic [7:0] BLK_CMD     = 8'h5C,
   parameter int         DATA_LEN    = 16,
   parameter int         SYNC_STAGES = 2,
   parameter int         IDX_W       = (DATA_LEN > 1) ? $clog2(DATA_LEN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic             busy_i,
   output logic [IDX_W-1:0] rd_idx,
   input  logic [7:0]       rd_data,
   output logic             rd_strb
);

   localparam logic [7:0]       COUNT_BYTE = 8'(DATA_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(DATA_LEN - 1);

   if (DATA_LEN < 1 || DATA_LEN > 255) begin : g_bad_len
      $error("smbr_blkread_slave: DATA_LEN must be in 1..255");
   end
   if (IDX_W < 1 || (2 ** IDX_W) < DATA_LEN) begin : g_bad_idx
      $error("smbr_blkread_slave: IDX_W too small for DATA_LEN");
   end

   // bus events
   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   smbr_bus_sense #(.STAGES(SYNC_STAGES)) i_sense (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   // state
   smbr_state_t      st, st_n;
   smbr_rxph_t       rph, rph_n;
   smbr_txph_t       tph, tph_n;
   logic             oe_q, oe_n;
   logic [7:0]       crc_q, crc_nxt, crc_byte;
   logic             crc_upd, crc_clr;
   logic [IDX_W-1:0] idx_q;
   logic             idx_clr, idx_inc;
   logic             lastsent_q, lastsent_n;
   logic             mack_q, mack_n;
   logic             strb;

   // byte shifter controls
   logic       br_clr, br_load, br_sample, br_adv;
   logic [7:0] br_val, br_q;
   logic [3:0] br_cnt;
   logic       rx_full, rx_ok;

   smbr_bytereg i_byte (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (br_clr),
      .load      (br_load),
      .load_val  (br_val),
      .sample    (br_sample),
      .sample_bit(sda_s),
      .adv       (br_adv),
      .q         (br_q),
      .cnt       (br_cnt)
   );

   smbr_crc8 #(.POLY(SMBR_PEC_POLY)) i_pec (
      .crc_i (crc_q),
      .byte_i(crc_byte),
      .crc_o (crc_nxt)
   );

   assign rx_full = (br_cnt == 4'd8);

   // acceptance of the byte just received
   always_comb begin
      unique case (rph)
         P_ADDR_WR: rx_ok = (br_q[7:1] == SLV_ADDR) && !br_q[0];
         P_CMD:     rx_ok = (br_q == BLK_CMD) && !busy_i;
         P_ADDR_RD: rx_ok = (br_q[7:1] == SLV_ADDR) &&  br_q[0];
         default:   rx_ok = 1'b0;
      endcase
   end

   // next-state logic
   always_comb begin
      st_n       = st;
      rph_n      = rph;
      tph_n      = tph;
      oe_n       = oe_q;
      mack_n     = mack_q;
      lastsent_n = lastsent_q;
      br_clr     = 1'b0;
      br_load    = 1'b0;
      br_sample  = 1'b0;
      br_adv     = 1'b0;
      br_val     = 8'h00;
      crc_upd    = 1'b0;
      crc_clr    = 1'b0;
      crc_byte   = br_q;
      idx_clr    = 1'b0;
      idx_inc    = 1'b0;
      strb       = 1'b0;

      if (stop_det) begin
         st_n = S_IDLE;
         oe_n = 1'b0;
      end else if (start_det) begin
         st_n   = S_RX;
         oe_n   = 1'b0;
         br_clr = 1'b1;
         if (st == S_WAITRS) begin
            rph_n = P_ADDR_RD;
         end else begin
            rph_n   = P_ADDR_WR;
            crc_clr = 1'b1;
         end
      end else begin
         unique case (st)
            S_RX: begin
               if (scl_rise && !rx_full) begin
                  br_sample = 1'b1;
               end else if (scl_fall && rx_full) begin
                  if (rx_ok) begin
                     st_n    = S_RXACK;
                     oe_n    = 1'b1;
                     crc_upd = 1'b1;
                  end else begin
                     st_n = S_HOLD;
                  end
               end
            end
            S_RXACK: begin
               if (scl_fall) begin
                  oe_n = 1'b0;
                  unique case (rph)
                     P_ADDR_WR: begin
                        st_n   = S_RX;
                        rph_n  = P_CMD;
                        br_clr = 1'b1;
                     end
                     P_CMD: begin
                        st_n = S_WAITRS;
                     end
                     default: begin
                        st_n       = S_TX;
                        tph_n      = T_COUNT;
                        br_load    = 1'b1;
                        br_val     = COUNT_BYTE;
                        crc_upd    = 1'b1;
                        crc_byte   = COUNT_BYTE;
                        oe_n       = ~COUNT_BYTE[7];
                        idx_clr    = 1'b1;
                        lastsent_n = 1'b0;
                     end
                  endcase
               end
            end
            S_TX: begin
               if (scl_fall) begin
                  if (br_cnt == 4'd7) begin
                     oe_n = 1'b0;
                     st_n = S_TXACK;
                  end else begin
                     br_adv = 1'b1;
                     oe_n   = ~br_q[6];
                  end
               end
            end
            S_TXACK: begin
               if (scl_rise) begin
                  mack_n = ~sda_s;
               end else if (scl_fall) begin
                  if (tph == T_PEC || !mack_q) begin
                     st_n = S_HOLD;
                  end else if (!lastsent_q) begin
                     st_n     = S_TX;
                     tph_n    = T_DATA;
                     br_load  = 1'b1;
                     br_val   = rd_data;
                     crc_upd  = 1'b1;
                     crc_byte = rd_data;
                     oe_n     = ~rd_data[7];
                     strb     = 1'b1;
                     if (idx_q == LAST_IDX) lastsent_n = 1'b1;
                     else                   idx_inc    = 1'b1;
                  end else begin
                     st_n    = S_TX;
                     tph_n   = T_PEC;
                     br_load = 1'b1;
                     br_val  = crc_q;
                     oe_n    = ~crc_q[7];
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         rph        <= P_ADDR_WR;
         tph        <= T_COUNT;
         oe_q       <= 1'b0;
         mack_q     <= 1'b0;
         lastsent_q <= 1'b0;
         crc_q      <= 8'h00;
         idx_q      <= '0;
      end else begin
         st         <= st_n;
         rph        <= rph_n;
         tph        <= tph_n;
         oe_q       <= oe_n;
         mack_q     <= mack_n;
         lastsent_q <= lastsent_n;
         if (crc_clr)      crc_q <= 8'h00;
         else if (crc_upd) crc_q <= crc_nxt;
         if (idx_clr)      idx_q <= '0;
         else if (idx_inc) idx_q <= idx_q + 1'b1;
      end
   end

   assign sda_oe  = oe_q;
   assign rd_idx  = idx_q;
   assign rd_strb = strb;

   // R11: the pull-down moves only while SCL is low
   a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q != $past(oe_q)) |-> !scl_s);

   // R2, R7: no driving while idle, waiting or silenced
   a_r2_quiet_when_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE || st == S_HOLD || st == S_WAITRS) |-> !oe_q);

   // R3: a busy parallel side never gets the command acknowledged
   a_r3_busy_refuses_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RX && rph == P_CMD && rx_full && scl_fall && busy_i) |=> (st != S_RXACK));

   // R4: first transmitted byte is the count
   a_r4_count_first: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_TX && $past(st) == S_RXACK) |-> (br_q == COUNT_BYTE));

   // R8: master NACK silences the slave
   a_r8_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_TXACK && scl_fall && !mack_q) |=> (st == S_HOLD && !oe_q));

   // R9: a START always restarts byte reception with SDA released
   a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st == S_RX && br_cnt == 4'd0 && !oe_q));

endmodule

// File: tb/test_smbr_blkread_slave.sv
`timescale 1ns/1ps
module test_smbr_blkread_slave;

   localparam logic [6:0] ADDR = 7'h2A;
   localparam logic [7:0] CMD  = 8'h5C;
   localparam int         LEN  = 16;
   localparam int         Q    = 10;   // clocks per quarter SCL period

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;              // 50 MHz

   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       busy  = 1'b0;
   logic       sda_oe;
   logic [3:0] rd_idx;
   logic [7:0] rd_data;
   logic       rd_strb;
   logic       sda_bus;
   int         pat = 0;

   assign sda_bus = sda_m & ~sda_oe;

   function automatic logic [7:0] src(input int i, input int p);
      return 8'(8'h3C ^ (i * 29) ^ (p * 8'hA5));
   endfunction

   assign rd_data = src(int'(rd_idx), pat);

   smbr_blkread_slave i_smbr_blkread_slave (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_m),
      .sda_i  (sda_bus),
      .sda_oe (sda_oe),
      .busy_i (busy),
      .rd_idx (rd_idx),
      .rd_data(rd_data),
      .rd_strb(rd_strb)
   );

   int n_chk = 0;
   int n_bad = 0;
   int strb_cnt = 0;
   int oe_cnt = 0;
   int scl_viol = 0;
   logic oe_prev = 1'b0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (rd_strb) strb_cnt++;
      if (sda_oe) oe_cnt++;
      if (rst_n && sda_oe != oe_prev && scl_m) scl_viol++;
      oe_prev = sda_oe;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] b);
      logic [7:0] r;
      r = c ^ b;
      for (int k = 0; k < 8; k++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
      return r;
   endfunction

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   // bus master primitives
   task automatic m_start();
      if (!scl_m) begin
         wq(Q); sda_m = 1'b1;
         wq(Q); scl_m = 1'b1;
      end else begin
         sda_m = 1'b1;
      end
      wq(Q); sda_m = 1'b0;
      wq(Q); scl_m = 1'b0;
   endtask

   task automatic m_stop();
      wq(Q); sda_m = 1'b0;
      wq(Q); scl_m = 1'b1;
      wq(Q); sda_m = 1'b1;
      wq(Q);
   endtask

   task automatic m_wbits(input logic [7:0] b, input int nb);
      for (int i = 0; i < nb; i++) begin
         wq(Q); sda_m = b[7-i];
         wq(Q); scl_m = 1'b1;
         wq(2*Q); scl_m = 1'b0;
      end
   endtask

   task automatic m_wbyte(input logic [7:0] b, output bit ack);
      m_wbits(b, 8);
      wq(Q); sda_m = 1'b1;
      wq(Q); scl_m = 1'b1;
      wq(Q); ack = !sda_bus;
      wq(Q); scl_m = 1'b0;
   endtask

   task automatic m_rbyte(input bit ack, output logic [7:0] b);
      sda_m = 1'b1;
      b = 8'h00;
      for (int i = 0; i < 8; i++) begin
         wq(2*Q); scl_m = 1'b1;
         wq(Q);   b = {b[6:0], sda_bus};
         wq(Q);   scl_m = 1'b0;
      end
      wq(Q); sda_m = !ack;
      wq(Q); scl_m = 1'b1;
      wq(2*Q); scl_m = 1'b0;
   endtask

   // full block read, starting with a START (plain or repeated)
   task automatic xfer_full(input int p, input string tag);
      bit ack;
      logic [7:0] b, c;
      pat = p;
      strb_cnt = 0;
      c = 8'h00;
      m_start();
      m_wbyte({ADDR, 1'b0}, ack); c = crc_add(c, {ADDR, 1'b0});
      chk(ack, {"R2 write address ACK ", tag}, ack, 1);
      m_wbyte(CMD, ack); c = crc_add(c, CMD);
      chk(ack, {"R3 command ACK ", tag}, ack, 1);
      m_start();
      m_wbyte({ADDR, 1'b1}, ack); c = crc_add(c, {ADDR, 1'b1});
      chk(ack, {"R4 read address ACK ", tag}, ack, 1);
      m_rbyte(1'b1, b); c = crc_add(c, b);
      chk(b == 8'(LEN), {"R4 byte count ", tag}, b, LEN);
      for (int i = 0; i < LEN; i++) begin
         m_rbyte(1'b1, b); c = crc_add(c, src(i, p));
         chk(b == src(i, p), {"R5 data byte ", tag}, b, src(i, p));
      end
      m_rbyte(1'b0, b);
      chk(b == c, {"R6 PEC ", tag}, b, c);
      chk(strb_cnt == LEN, {"R5 strobe count ", tag}, strb_cnt, LEN);
      wq(4);
      chk(sda_oe == 1'b0, {"R7 released after PEC ", tag}, sda_oe, 0);
      m_stop();
   endtask

   task automatic t_reset();
      chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
      chk(rd_strb == 1'b0, "R1 rd_strb after reset", rd_strb, 0);
   endtask

   task automatic t_wrong_addr();
      bit ack;
      m_start();
      m_wbyte({ADDR ^ 7'h01, 1'b0}, ack);
      chk(!ack, "R2 foreign address NACK", ack, 0);
      oe_cnt = 0;
      m_wbyte(CMD, ack);
      chk(!ack && oe_cnt == 0, "R2 silent after foreign address", oe_cnt, 0);
      m_stop();
   endtask

   task automatic t_busy();
      bit ack;
      busy = 1'b1;
      m_start();
      m_wbyte({ADDR, 1'b0}, ack);
      chk(ack, "R3 address ACK while busy", ack, 1);
      m_wbyte(CMD, ack);
      chk(!ack, "R3 command NACK while busy", ack, 0);
      m_stop();
      busy = 1'b0;
   endtask

   task automatic t_bad_cmd();
      bit ack;
      m_start();
      m_wbyte({ADDR, 1'b0}, ack);
      m_wbyte(CMD ^ 8'h01, ack);
      chk(!ack, "R3 other command NACK", ack, 0);
      m_stop();
   endtask

   task automatic t_stop_mid();
      bit ack;
      m_start();
      m_wbyte({ADDR, 1'b0}, ack);
      m_wbyte(CMD, ack);
      chk(ack, "R10 command ACK before STOP", ack, 1);
      m_stop();
      m_start();
      m_wbyte({ADDR, 1'b1}, ack);
      chk(!ack, "R10 read address after STOP NACK", ack, 0);
      m_stop();
   endtask

   task automatic t_early_nack();
      bit ack;
      logic [7:0] b;
      pat = 2;
      m_start();
      m_wbyte({ADDR, 1'b0}, ack);
      m_wbyte(CMD, ack);
      m_start();
      m_wbyte({ADDR, 1'b1}, ack);
      m_rbyte(1'b1, b);
      m_rbyte(1'b1, b);
      chk(b == src(0, 2), "R8 data before NACK", b, src(0, 2));
      m_rbyte(1'b0, b);
      chk(b == src(1, 2), "R8 NACKed data byte", b, src(1, 2));
      oe_cnt = 0;
      m_rbyte(1'b0, b);
      chk(b == 8'hFF && oe_cnt == 0, "R8 silent after NACK", b, 8'hFF);
      m_stop();
   endtask

   task automatic t_abort();
      bit ack;
      m_start();
      m_wbyte({ADDR, 1'b0}, ack);
      chk(ack, "R9 address ACK before abort", ack, 1);
      m_wbits(CMD, 3);
      xfer_full(1, "R9 after abort");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         chk(scl_viol == 0, "R11 sda_oe changed with SCL high", scl_viol, 0);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_run();
   end

   initial begin
      wq(5);
      t_reset();
      rst_n = 1'b1;
      wq(20);
      xfer_full(0, "R7 first");
      xfer_full(1, "R7 second");
      t_wrong_addr();
      t_busy();
      t_bad_cmd();
      t_stop_mid();
      t_early_nack();
      t_abort();
      xfer_full(3, "R7 final");
      finish_run();
   end

endmodule